// File: doc/BRIEF.md
# Multi-Source Reset Controller with Release Stretch

This block gathers five reset requests into one internal system reset: a power-on detector output, an active-low external reset pin, a watchdog expiry, a supply brown-out indication and a reset bit held by a debug port. The watchdog and brown-out requests count only when their enable inputs are set. The external pin passes through a glitch filter and must stay low for a minimum number of clock cycles before it is taken as a request. The voltage detectors, the watchdog timer and the debug logic all sit outside the block and reach it as plain digital inputs.

A gated request drives a port-reset output low through logic alone, with no clock edge involved. The same request clears the internal system reset flops asynchronously. When the last request goes away, release passes through a two-flop synchronizer and then a delay counter. A static 3-bit configuration field sets the length of that counter. A sticky cause register holds one flag per source so that software can tell what caused the last reset. The block also presents a fixed reset-vector address for the processor fetch after release.

Top module: `rstctl_top`

## Requirements
- R1: `port_rst_n_o` is low whenever any gated request is active (power-on high, accepted external request, enabled watchdog expiry, enabled brown-out, debug bit high). It follows the request through combinational logic with no clock edge, and `sys_rst_n_o` is low whenever `port_rst_n_o` is low.
- R2: `wdt_expire_i` has no effect on either reset output or on the cause flags while `wdt_en_i` is 0.
- R3: `bod_low_i` has no effect on either reset output or on the cause flags while `bod_en_i` is 0.
- R4: A low level on `ext_rst_n_i` becomes a request only if the pin is sampled low on at least MIN_LOW (default 6) consecutive rising clock edges. Shorter low pulses leave both reset outputs and the cause flags unchanged.
- R5: `sys_rst_n_o` stays low while any request is active. After the last request drops, it rises on the (3+N)-th rising edge, where N is selected by `dly_sel_i`: 0→0, 1→16, 2→128, 3→1024, 4→4096, 5→16384, 6→65536, 7 (reserved)→65536.
- R6: While `dbg_rst_i` is 1, `sys_rst_n_o` stays low for any length of time.
- R7: The cause flags are `cause_o[0]` power-on, `[1]` external, `[2]` watchdog, `[3]` brown-out and `[4]` debug. A flag is set at a rising edge where its gated request is active, and it stays set until software clears it.
- R8: While `por_i` is high, `cause_o` equals 5'b00001, so every other flag is cleared.
- R9: On a rising edge with `clr_we_i` high, each flag whose bit in `clr_mask_i` is 1 is cleared. A request that is active on that same edge wins, and its flag stays set.
- R10: `rst_vec_o` always equals the parameter RST_VEC (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| por_i | input | 1 | Power-on detector output, high while supply is below threshold |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdt_expire_i | input | 1 | Watchdog expiry request |
| wdt_en_i | input | 1 | Watchdog reset enable |
| bod_low_i | input | 1 | Brown-out detector output, high on low supply |
| bod_en_i | input | 1 | Brown-out reset enable |
| dbg_rst_i | input | 1 | Debug-port reset bit |
| dly_sel_i | input | 3 | Static release-delay select |
| clr_we_i | input | 1 | Cause flag clear strobe |
| clr_mask_i | input | 5 | Write-one-to-clear mask for cause flags |
| port_rst_n_o | output | 1 | Immediate port reset, active low, combinational |
| sys_rst_n_o | output | 1 | Stretched internal system reset, active low |
| cause_o | output | 5 | Sticky reset cause flags |
| rst_vec_o | output | 16 | Fixed reset vector address |

## Verification
On every cycle the assertions check four things: the system reset is never released while the port reset is asserted; the released state holds until a new request arrives; the delay counter releases exactly at its limit and never runs past it; and the cause flags only rise, except when software clears them. The filter's acceptance count and the power-on one-hot pattern are also checked on every cycle. Only the bench scenarios can show the absolute release timing for each of the eight delay codes, the accept/reject boundary of the pin filter across pulse lengths, and the fact that disabled watchdog and brown-out requests leave every output untouched.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int NSRC      = 5;
    localparam int SRC_POR   = 0;
    localparam int SRC_EXT   = 1;
    localparam int SRC_WDT   = 2;
    localparam int SRC_BOD   = 3;
    localparam int SRC_DBG   = 4;

    localparam int DLY_SEL_W = 3;
    localparam int DLY_EXP_1 = 4;
    localparam int DLY_EXP_2 = 7;
    localparam int DLY_EXP_3 = 10;
    localparam int DLY_EXP_4 = 12;
    localparam int DLY_EXP_5 = 14;
    localparam int DLY_EXP_6 = 16;
    localparam int DLY_MAX   = 1 << DLY_EXP_6;
    localparam int DLY_CNT_W = $clog2(DLY_MAX + 1);

    typedef logic [DLY_CNT_W-1:0] dly_cnt_t;

    // Map the static select code to the number of stretch cycles.
    function automatic dly_cnt_t dly_limit(input logic [DLY_SEL_W-1:0] sel);
        dly_cnt_t one;
        one = dly_cnt_t'(1);
        case (sel)
            3'd0:    dly_limit = '0;
            3'd1:    dly_limit = one << DLY_EXP_1;
            3'd2:    dly_limit = one << DLY_EXP_2;
            3'd3:    dly_limit = one << DLY_EXP_3;
            3'd4:    dly_limit = one << DLY_EXP_4;
            3'd5:    dly_limit = one << DLY_EXP_5;
            default: dly_limit = one << DLY_EXP_6;
        endcase
    endfunction

endpackage

// File: rtl/rstctl_pin_filter.sv
module rstctl_pin_filter #(
    parameter int MIN_LOW = 6,
    parameter int FILT_W  = 4
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic pin_n_i,
    output logic req_o
);
    localparam logic [FILT_W-1:0] LIM    = FILT_W'(MIN_LOW);
    localparam logic [FILT_W-1:0] LIM_M1 = FILT_W'(MIN_LOW - 1);

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic [FILT_W-1:0] cnt;
        logic              acc;
    } filt_t;

    localparam filt_t FILT_RST = '{s1: 1'b1, s2: 1'b1, cnt: '0, acc: 1'b0};

    filt_t filt_d, filt_q;
    logic  acc_q;
    logic [FILT_W-1:0] cnt_q;

    always_comb begin
        filt_d    = filt_q;
        filt_d.s1 = pin_n_i;
        filt_d.s2 = filt_q.s1;
        if (filt_q.s2) begin
            filt_d.cnt = '0;
            filt_d.acc = 1'b0;
        end else begin
            if (filt_q.cnt != LIM) begin
                filt_d.cnt = filt_q.cnt + 1'b1;
            end
            filt_d.acc = (filt_q.cnt >= LIM_M1);
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            filt_q <= FILT_RST;
        end else begin
            filt_q <= filt_d;
        end
    end

    assign acc_q = filt_q.acc;
    assign cnt_q = filt_q.cnt;
    assign req_o = acc_q;

    // R4
    accept_len_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(acc_q) |-> (cnt_q == LIM));

    // R4
    pin_high_drop_chk: assert property (@(posedge clk_i) disable iff (por_i)
        filt_q.s2 |=> !acc_q);

endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
    parameter int CNT_W = 17
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             rst_n_o
);
    typedef struct packed {
        logic [1:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             rel;
    } strt_t;

    localparam strt_t STRT_RST = '{sync: 2'b00, cnt: '0, rel: 1'b0};

    strt_t strt_d, strt_q;
    logic  rel_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        strt_d      = strt_q;
        strt_d.sync = {strt_q.sync[0], 1'b1};
        if (strt_q.sync[1] && !strt_q.rel) begin
            if (strt_q.cnt == lim_i) begin
                strt_d.rel = 1'b1;
            end else begin
                strt_d.cnt = strt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            strt_q <= STRT_RST;
        end else begin
            strt_q <= strt_d;
        end
    end

    assign rel_q   = strt_q.rel;
    assign cnt_q   = strt_q.cnt;
    assign rst_n_o = rel_q;

    // R5
    release_at_limit_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        $rose(rel_q) |-> (cnt_q == lim_i));

    // R5
    no_overrun_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        cnt_q <= lim_i);

    // R5
    release_hold_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        rel_q |=> rel_q);

endmodule

// File: rtl/rstctl_cause.sv
module rstctl_cause #(
    parameter int NSRC = 5
) (
    input  logic            clk_i,
    input  logic            por_i,
    input  logic [NSRC-1:0] src_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_mask_i,
    output logic [NSRC-1:0] cause_o
);
    localparam logic [NSRC-1:0] POR_ONLY = NSRC'(1);

    typedef struct packed {
        logic [NSRC-1:0] flags;
    } cause_t;

    cause_t          cause_d, cause_q;
    logic [NSRC-1:0] next_bits;
    logic [NSRC-1:0] keep_bits;

    for (genvar b = 0; b < NSRC; b++) begin : g_flag
        assign keep_bits[b] = cause_q.flags[b] & ~(clr_we_i & clr_mask_i[b]);
        assign next_bits[b] = src_i[b] | keep_bits[b];
    end

    always_comb begin
        cause_d       = cause_q;
        cause_d.flags = next_bits;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            cause_q <= '{flags: POR_ONLY};
        end else begin
            cause_q <= cause_d;
        end
    end

    assign cause_o = cause_q.flags;

    // R7
    sticky_flag_chk: assert property (@(posedge clk_i) disable iff (por_i)
        1'b1 |=> ((cause_o & $past(keep_bits)) == $past(keep_bits)));

    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (por_i)
        1'b1 |=> ((cause_o & $past(src_i)) == $past(src_i)));

    // R8
    por_onehot_chk: assert property (@(posedge clk_i)
        por_i |-> (cause_o == POR_ONLY));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top #(
    parameter int          MIN_LOW = 6,
    parameter int          FILT_W  = 4,
    parameter int          VEC_W   = 16,
    parameter logic [15:0] RST_VEC = 16'h0000
) (
    input  logic                             clk_i,
    input  logic                             por_i,
    input  logic                             ext_rst_n_i,
    input  logic                             wdt_expire_i,
    input  logic                             wdt_en_i,
    input  logic                             bod_low_i,
    input  logic                             bod_en_i,
    input  logic                             dbg_rst_i,
    input  logic [rstctl_pkg::DLY_SEL_W-1:0] dly_sel_i,
    input  logic                             clr_we_i,
    input  logic [rstctl_pkg::NSRC-1:0]      clr_mask_i,
    output logic                             port_rst_n_o,
    output logic                             sys_rst_n_o,
    output logic [rstctl_pkg::NSRC-1:0]      cause_o,
    output logic [VEC_W-1:0]                 rst_vec_o
);
    import rstctl_pkg::*;

    logic [NSRC-1:0] src;
    logic            ext_req;
    logic            any_src;
    dly_cnt_t        lim;

    rstctl_pin_filter #(
        .MIN_LOW (MIN_LOW),
        .FILT_W  (FILT_W)
    ) u_filter (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .pin_n_i (ext_rst_n_i),
        .req_o   (ext_req)
    );

    always_comb begin
        src          = '0;
        src[SRC_POR] = por_i;
        src[SRC_EXT] = ext_req;
        src[SRC_WDT] = wdt_expire_i & wdt_en_i;
        src[SRC_BOD] = bod_low_i & bod_en_i;
        src[SRC_DBG] = dbg_rst_i;
    end

    assign any_src      = |src;
    assign port_rst_n_o = ~any_src;
    assign lim          = dly_limit(dly_sel_i);
    assign rst_vec_o    = VEC_W'(RST_VEC);

    rstctl_stretch #(
        .CNT_W (DLY_CNT_W)
    ) u_stretch (
        .clk_i   (clk_i),
        .arst_i  (any_src),
        .lim_i   (lim),
        .rst_n_o (sys_rst_n_o)
    );

    rstctl_cause #(
        .NSRC (NSRC)
    ) u_cause (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .src_i      (src),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .cause_o    (cause_o)
    );

    // R1
    port_implies_sys_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !port_rst_n_o |-> !sys_rst_n_o);

endmodule

// File: tb/test_rstctl_top.sv
module test_rstctl_top;

    logic       clk = 1'b0;
    logic       por, pin_n, wdt, wdt_en, bod, bod_en, dbg, clr_we;
    logic [2:0] dly_sel;
    logic [4:0] clr_mask;
    logic       port_n, sys_n;
    logic [4:0] cause;
    logic [15:0] vec;

    int checks = 0;
    int fails  = 0;
    bit saw_port_low;

    always #5 clk = ~clk;

    rstctl_top i_rstctl_top (
        .clk_i        (clk),
        .por_i        (por),
        .ext_rst_n_i  (pin_n),
        .wdt_expire_i (wdt),
        .wdt_en_i     (wdt_en),
        .bod_low_i    (bod),
        .bod_en_i     (bod_en),
        .dbg_rst_i    (dbg),
        .dly_sel_i    (dly_sel),
        .clr_we_i     (clr_we),
        .clr_mask_i   (clr_mask),
        .port_rst_n_o (port_n),
        .sys_rst_n_o  (sys_n),
        .cause_o      (cause),
        .rst_vec_o    (vec)
    );

    always @(negedge port_n) saw_port_low = 1'b1;

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_dly(input int sel);
        case (sel)
            0: return 0;
            1: return 16;
            2: return 128;
            3: return 1024;
            4: return 4096;
            5: return 16384;
            default: return 65536;
        endcase
    endfunction

    // Called right after the last request drops (between edges).
    task automatic release_check(input int n, input string tag);
        repeat (n + 2) @(posedge clk);
        #2 chk_eq({tag, " still held"}, sys_n, 0);
        @(posedge clk);
        #2 chk_eq({tag, " released"}, sys_n, 1);
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_we = 1'b1; clr_mask = 5'b11111;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = 5'b00000;
    endtask

    initial begin
        por = 0; pin_n = 1; wdt = 0; wdt_en = 0; bod = 0; bod_en = 0;
        dbg = 0; clr_we = 0; clr_mask = 0; dly_sel = 0;

        // Power-on
        #1 por = 1'b1;
        #1 chk_eq("R1 port low on power-on", port_n, 0);
        chk_eq("R1 sys low on power-on", sys_n, 0);
        repeat (3) @(negedge clk);
        chk_eq("R8 cause during power-on", cause, 5'b00001);
        por = 1'b0;
        release_check(0, "R5 power-on");
        chk_eq("R8 cause after power-on", cause, 5'b00001);
        chk_eq("R1 port high idle", port_n, 1);
        chk_eq("R10 reset vector", vec, 0);

        // r9_ clear power-on flag
        @(negedge clk);
        clr_we = 1'b1; clr_mask = 5'b00001;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = 5'b00000;
        chk_eq("R9 write-one clear", cause, 0);

        // R2 watchdog gated off, then on
        wdt = 1'b1;
        #1 chk_eq("R2 disabled watchdog port", port_n, 1);
        @(negedge clk);
        wdt = 1'b0;
        chk_eq("R2 disabled watchdog cause", cause, 0);
        chk_eq("R2 disabled watchdog sys", sys_n, 1);
        wdt_en = 1'b1; wdt = 1'b1;
        #1 chk_eq("R2 enabled watchdog port", port_n, 0);
        @(negedge clk);
        wdt = 1'b0;
        chk_eq("R7 watchdog flag", cause, 5'b00100);
        release_check(0, "R2 watchdog");

        // R3 brown-out gated off, then on
        @(negedge clk);
        bod = 1'b1;
        #1 chk_eq("R3 disabled brown-out port", port_n, 1);
        @(negedge clk);
        bod = 1'b0;
        chk_eq("R3 disabled brown-out cause", cause, 5'b00100);
        chk_eq("R3 disabled brown-out sys", sys_n, 1);
        bod_en = 1'b1; bod = 1'b1;
        #1 chk_eq("R3 enabled brown-out port", port_n, 0);
        @(negedge clk);
        bod = 1'b0;
        chk_eq("R7 brown-out flag sticky", cause, 5'b01100);
        release_check(0, "R3 brown-out");
        clear_all();
        chk_eq("R9 clear all", cause, 0);

        // R4 pulse-length sweep on the external pin (MIN_LOW = 6)
        for (int n = 1; n <= 9; n++) begin
            bit acc;
            acc = (n >= 6);
            @(negedge clk);
            saw_port_low = 1'b0;
            pin_n = 1'b0;
            repeat (n) @(negedge clk);
            pin_n = 1'b1;
            repeat (12) @(negedge clk);
            chk_eq($sformatf("R4 pulse %0d port reset seen", n), saw_port_low, acc);
            chk_eq($sformatf("R7 pulse %0d external flag", n), cause[1], acc);
            chk_eq($sformatf("R4 pulse %0d sys released", n), sys_n, 1);
            clear_all();
        end

        // R9 set wins over clear; R6 long debug hold
        @(negedge clk);
        dbg = 1'b1;
        @(negedge clk);
        clr_we = 1'b1; clr_mask = 5'b10000;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = 5'b00000;
        chk_eq("R9 active request beats clear", cause, 5'b10000);
        begin
            int low_cnt;
            low_cnt = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!sys_n) low_cnt++;
            end
            chk_eq("R6 debug hold cycles low", low_cnt, 40);
        end
        dbg = 1'b0;
        release_check(0, "R6 debug");

        // R5 overlapping requests
        @(negedge clk);
        dbg = 1'b1; bod = 1'b1;
        @(negedge clk);
        dbg = 1'b0;
        repeat (5) @(negedge clk);
        chk_eq("R5 held by remaining request", sys_n, 0);
        bod = 1'b0;
        release_check(0, "R5 overlap");

        // R8 power-on wipes other flags
        chk_eq("R7 flags before power-on", cause, 5'b11000);
        @(negedge clk);
        por = 1'b1;
        @(negedge clk);
        chk_eq("R8 power-on one-hot", cause, 5'b00001);
        por = 1'b0;
        release_check(0, "R5 second power-on");

        // R5 delay-select sweep over all eight codes
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            dly_sel = 3'(s);
            dbg = 1'b1;
            @(negedge clk);
            dbg = 1'b0;
            release_check(exp_dly(s), $sformatf("R5 delay code %0d", s));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule